// File: doc/BRIEF.md
# Translation Cache with Fill-Log Flush

This block is a direct-indexed cache of page translations. A linear page number selects one slot. The slot holds a physical page number and two separate valid bits, one for reads and one for writes. A lookup returns two results: whether a read of that page would hit and whether a write would hit. Both results come with the stored physical page. The walker that finds translations and the memory behind them live outside the block. The walker loads results in with fill commands. A normal fill opens the page to both reads and writes. A read-only fill opens it to reads only, so a later write misses and goes back to the walker for a permission recheck.

Every accepted fill also pushes its linear page number onto a small stack, the fill log. A flush does not sweep the whole array. It pops the log one page per cycle and clears only the slots that were actually loaded. If a fill arrives while the log is full, the block first runs a complete flush and then performs that fill. A range invalidate clears a run of consecutive pages, one page per cycle. When the page being cleared is the newest log entry, that entry is popped, so the log does not fill up with dead pages.

A small state machine controls all of this. It has three states: `ST_IDLE`, `ST_FLUSH` and `ST_UNLINK`. The transitions are:
- idle to flush, on a flush command or on a fill that meets a full log;
- flush to itself, while the log is not empty;
- flush to idle, once the log is empty, performing any held-back fill on that cycle;
- idle to unlink, on a range invalidate;
- unlink to itself, while pages remain;
- unlink to idle, when the remaining count reaches zero.

`busy` is high in every state except idle. While it is high, lookups and commands are ignored.

Top module: `tlb_logflush`

## Requirements
- R1: After reset, `busy` and `fill_illegal` are low, and every lookup misses for both reads and writes.
- R2: A normal fill (`cmd_op`=0) of page P with physical page Q makes a later lookup of P return a read hit, a write hit and `lk_ppn`=Q. A later fill of the same page overwrites the slot.
- R3: A read-only fill (`cmd_op`=1) makes a later lookup of the page return a read hit, a write miss and the stored physical page.
- R4: A flush (`cmd_op`=3) clears both valid bits of every logged page, one page per cycle, and empties the log. `busy` stays high for (logged entries + 1) cycles.
- R5: A fill that arrives while the log holds LOG_DEPTH entries first flushes all logged pages and then performs the fill. `busy` stays high for LOG_DEPTH+1 cycles. Afterwards only the new page is valid and the log holds one entry.
- R6: A range invalidate (`cmd_op`=2) clears both valid bits of `cmd_count` consecutive pages starting at `cmd_page`, one page per cycle. `busy` stays high for `cmd_count`+1 cycles. A count of zero changes nothing.
- R7: When a range invalidate clears the page that is the newest log entry, that entry is popped. Log space is then reclaimed, so a later fill does not trigger a flush.
- R8: A fill whose linear or physical page is at or above NUM_ENTRIES raises `fill_illegal` for exactly one cycle, starting the cycle after the command. It writes no slot and logs nothing.
- R9: While `busy` is high, lookups are not acknowledged and commands are dropped.
- R10: A lookup accepted in idle is answered on the next cycle, with `lk_ack` high. Pages at or above NUM_ENTRIES miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken only in idle |
| cmd_op | input | 2 | 0 fill, 1 read-only fill, 2 range invalidate, 3 flush |
| cmd_page | input | LPN_W | Linear page for a fill, or first page of a range |
| cmd_ppn | input | PPN_W | Physical page for a fill |
| cmd_count | input | CNT_W | Page count for a range invalidate |
| busy | output | 1 | A flush or an invalidate walk is in progress |
| fill_illegal | output | 1 | One-cycle pulse: the last fill was out of range |
| lk_req | input | 1 | Lookup request |
| lk_page | input | LPN_W | Linear page to look up |
| lk_ack | output | 1 | Lookup answer is valid this cycle |
| lk_rd_hit | output | 1 | A read of the page would hit |
| lk_wr_hit | output | 1 | A write of the page would hit |
| lk_ppn | output | PPN_W | Stored physical page |

## Verification
The bench fills the log exactly to its depth and then adds one more fill. A design that skipped the forced flush would overrun the log, and a design that flushed but dropped the pending fill would miss on the new page. It clears the newest logged page and fills again. A design that left the dead entry in the log would flush early and lose the older pages. It counts `busy` cycles for flushes of several log sizes, so a sweep over the whole array, or an off-by-one in the walk, shows up as a wrong count. It also checks that read-only slots refuse writes, that an out-of-range page on either side raises the error pulse and is left unstored, and that lookups and commands given during a flush are dropped.

// File: rtl/tlbl_pkg.sv
package tlbl_pkg;

    typedef enum logic [1:0] {
        OP_FILL    = 2'd0,
        OP_FILL_RO = 2'd1,
        OP_INVAL   = 2'd2,
        OP_FLUSH   = 2'd3
    } tlb_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FLUSH  = 2'd1,
        ST_UNLINK = 2'd2
    } tlb_state_e;

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
    parameter int NUM_ENTRIES = 64,
    parameter int PPN_W       = 8,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [PPN_W-1:0] set_ppn,
    input  logic             set_ro,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic             look_en,
    input  logic             look_ok,
    input  logic [IDX_W-1:0] look_idx,
    output logic             look_rd,
    output logic             look_wr,
    output logic [PPN_W-1:0] look_ppn
);

    logic [NUM_ENTRIES-1:0] rd_valid;
    logic [NUM_ENTRIES-1:0] wr_valid;
    logic [PPN_W-1:0]       ppn_mem [NUM_ENTRIES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= '0;
            wr_valid <= '0;
        end else begin
            if (set_en) begin
                rd_valid[set_idx] <= 1'b1;
                wr_valid[set_idx] <= !set_ro;
            end
            if (clr_en) begin
                rd_valid[clr_idx] <= 1'b0;
                wr_valid[clr_idx] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (set_en) ppn_mem[set_idx] <= set_ppn;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            look_rd  <= 1'b0;
            look_wr  <= 1'b0;
            look_ppn <= '0;
        end else if (look_en) begin
            look_rd  <= look_ok && rd_valid[look_idx];
            look_wr  <= look_ok && wr_valid[look_idx];
            look_ppn <= ppn_mem[look_idx];
        end
    end

    // R3
    ro_fill_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && set_ro) |=> !wr_valid[$past(set_idx)]);

endmodule

// File: rtl/tlb_fill_log.sv
module tlb_fill_log #(
    parameter int DEPTH = 8,
    parameter int W     = 6,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_en,
    input  logic [W-1:0]     push_val,
    input  logic             pop_en,
    output logic [W-1:0]     top_val,
    output logic [CNT_W-1:0] count,
    output logic             full
);

    logic [W-1:0]     slots [DEPTH];
    logic [CNT_W-1:0] top_pos;

    assign top_pos = count - 1'b1;
    assign full    = (count == CNT_W'(DEPTH));
    assign top_val = (count != '0) ? slots[top_pos[PTR_W-1:0]] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (push_en) begin
            count <= count + 1'b1;
        end else if (pop_en) begin
            count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push_en) slots[count[PTR_W-1:0]] <= push_val;
    end

    // R5
    log_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |-> (count < CNT_W'(DEPTH)));

    // R7
    log_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_en |-> (count != '0));

endmodule

// File: rtl/tlb_logflush.sv
module tlb_logflush
    import tlbl_pkg::*;
#(
    parameter int NUM_ENTRIES = 64,
    parameter int LOG_DEPTH   = 8,
    parameter int LPN_W       = 8,
    parameter int PPN_W       = 8,
    parameter int CNT_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [LPN_W-1:0] cmd_page,
    input  logic [PPN_W-1:0] cmd_ppn,
    input  logic [CNT_W-1:0] cmd_count,
    output logic             busy,
    output logic             fill_illegal,
    input  logic             lk_req,
    input  logic [LPN_W-1:0] lk_page,
    output logic             lk_ack,
    output logic             lk_rd_hit,
    output logic             lk_wr_hit,
    output logic [PPN_W-1:0] lk_ppn
);

    localparam int IDX_W  = $clog2(NUM_ENTRIES);
    localparam int LCNT_W = $clog2(LOG_DEPTH + 1);
    localparam logic [LPN_W:0] LPN_LIM = (LPN_W + 1)'(NUM_ENTRIES);
    localparam logic [PPN_W:0] PPN_LIM = (PPN_W + 1)'(NUM_ENTRIES);

    if (LOG_DEPTH > NUM_ENTRIES) begin : g_bad_depth
        $error("fill log deeper than the entry array");
    end

    tlb_state_e state, nxt;

    logic             pend_q;
    logic [IDX_W-1:0] pend_page_q;
    logic [PPN_W-1:0] pend_ppn_q;
    logic             pend_ro_q;
    logic [LPN_W-1:0] walk_page_q;
    logic [CNT_W-1:0] walk_left_q;
    logic             illegal_q, ack_q;

    logic             st_set, st_ro, st_clr;
    logic [IDX_W-1:0] st_idx, st_clr_idx;
    logic [PPN_W-1:0] st_ppn;
    logic             log_push, log_pop, log_full;
    logic [IDX_W-1:0] log_top;
    logic [LCNT_W-1:0] log_cnt;
    logic             illegal_d, load_pend, load_walk, walk_step;
    logic             cmd_bad, walk_in, look_en;

    assign cmd_bad = ({1'b0, cmd_page} >= LPN_LIM) || ({1'b0, cmd_ppn} >= PPN_LIM);
    assign walk_in = ({1'b0, walk_page_q} < LPN_LIM);
    assign busy    = (state != ST_IDLE);
    assign look_en = lk_req && (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt        = state;
        st_set     = 1'b0;
        st_ro      = 1'b0;
        st_idx     = '0;
        st_ppn     = '0;
        st_clr     = 1'b0;
        st_clr_idx = '0;
        log_push   = 1'b0;
        log_pop    = 1'b0;
        illegal_d  = 1'b0;
        load_pend  = 1'b0;
        load_walk  = 1'b0;
        walk_step  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    unique case (tlb_op_e'(cmd_op))
                        OP_FILL, OP_FILL_RO: begin
                            if (cmd_bad) begin
                                illegal_d = 1'b1;
                            end else if (log_full) begin
                                load_pend = 1'b1;
                                nxt       = ST_FLUSH;
                            end else begin
                                st_set   = 1'b1;
                                st_ro    = (cmd_op == OP_FILL_RO);
                                st_idx   = cmd_page[IDX_W-1:0];
                                st_ppn   = cmd_ppn;
                                log_push = 1'b1;
                            end
                        end
                        OP_INVAL: begin
                            load_walk = 1'b1;
                            nxt       = ST_UNLINK;
                        end
                        OP_FLUSH: nxt = ST_FLUSH;
                        default:  nxt = ST_IDLE;
                    endcase
                end
            end
            ST_FLUSH: begin
                if (log_cnt != '0) begin
                    st_clr     = 1'b1;
                    st_clr_idx = log_top;
                    log_pop    = 1'b1;
                end else begin
                    if (pend_q) begin
                        st_set   = 1'b1;
                        st_ro    = pend_ro_q;
                        st_idx   = pend_page_q;
                        st_ppn   = pend_ppn_q;
                        log_push = 1'b1;
                    end
                    nxt = ST_IDLE;
                end
            end
            ST_UNLINK: begin
                if (walk_left_q == '0) begin
                    nxt = ST_IDLE;
                end else begin
                    walk_step = 1'b1;
                    if (walk_in) begin
                        st_clr     = 1'b1;
                        st_clr_idx = walk_page_q[IDX_W-1:0];
                        log_pop    = (log_cnt != '0) && (log_top == walk_page_q[IDX_W-1:0]);
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_page_q <= '0;
            pend_ppn_q  <= '0;
            pend_ro_q   <= 1'b0;
            walk_page_q <= '0;
            walk_left_q <= '0;
            illegal_q   <= 1'b0;
            ack_q       <= 1'b0;
        end else begin
            illegal_q <= illegal_d;
            ack_q     <= look_en;
            if (load_pend) begin
                pend_q      <= 1'b1;
                pend_page_q <= cmd_page[IDX_W-1:0];
                pend_ppn_q  <= cmd_ppn;
                pend_ro_q   <= (cmd_op == OP_FILL_RO);
            end else if (state == ST_FLUSH && log_cnt == '0) begin
                pend_q <= 1'b0;
            end
            if (load_walk) begin
                walk_page_q <= cmd_page;
                walk_left_q <= cmd_count;
            end else if (walk_step) begin
                walk_page_q <= walk_page_q + 1'b1;
                walk_left_q <= walk_left_q - 1'b1;
            end
        end
    end

    assign fill_illegal = illegal_q;
    assign lk_ack       = ack_q;

    tlb_entry_store #(.NUM_ENTRIES(NUM_ENTRIES), .PPN_W(PPN_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (st_set),
        .set_idx  (st_idx),
        .set_ppn  (st_ppn),
        .set_ro   (st_ro),
        .clr_en   (st_clr),
        .clr_idx  (st_clr_idx),
        .look_en  (look_en),
        .look_ok  ({1'b0, lk_page} < LPN_LIM),
        .look_idx (lk_page[IDX_W-1:0]),
        .look_rd  (lk_rd_hit),
        .look_wr  (lk_wr_hit),
        .look_ppn (lk_ppn)
    );

    tlb_fill_log #(.DEPTH(LOG_DEPTH), .W(IDX_W)) u_log (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_en  (log_push),
        .push_val (st_idx),
        .pop_en   (log_pop),
        .top_val  (log_top),
        .count    (log_cnt),
        .full     (log_full)
    );

    // R8
    illegal_keeps_log_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_illegal |-> (log_cnt == $past(log_cnt)));

    // R4
    flush_walk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLUSH && log_cnt != '0) |=> (log_cnt == $past(log_cnt) - 1'b1));

endmodule

// File: tb/sim_tlb_logflush.sv
`timescale 1ns/1ps
module sim_tlb_logflush;

    localparam int DEPTH = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [7:0] cmd_page = '0;
    logic [7:0] cmd_ppn = '0;
    logic [3:0] cmd_count = '0;
    logic       busy, fill_illegal;
    logic       lk_req = 1'b0;
    logic [7:0] lk_page = '0;
    logic       lk_ack, lk_rd_hit, lk_wr_hit;
    logic [7:0] lk_ppn;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    tlb_logflush u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_page(cmd_page), .cmd_ppn(cmd_ppn), .cmd_count(cmd_count),
        .busy(busy), .fill_illegal(fill_illegal), .lk_req(lk_req),
        .lk_page(lk_page), .lk_ack(lk_ack), .lk_rd_hit(lk_rd_hit),
        .lk_wr_hit(lk_wr_hit), .lk_ppn(lk_ppn)
    );

    typedef struct packed {
        logic [3:0] req;
        logic [1:0] op;
        logic [7:0] page;
        logic [7:0] ppn;
        logic [3:0] cnt;
        logic [7:0] lk;
        logic       rd;
        logic       wr;
        logic [7:0] xppn;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{4'd2,  2'd0, 8'd3,  8'h21, 4'd0, 8'd3,  1'b1, 1'b1, 8'h21}, // R2
        '{4'd3,  2'd1, 8'd5,  8'h07, 4'd0, 8'd5,  1'b1, 1'b0, 8'h07}, // R3
        '{4'd2,  2'd0, 8'd10, 8'h3F, 4'd0, 8'd10, 1'b1, 1'b1, 8'h3F}, // R2
        '{4'd6,  2'd2, 8'd10, 8'h00, 4'd1, 8'd10, 1'b0, 1'b0, 8'h00}, // R6
        '{4'd6,  2'd2, 8'd0,  8'h00, 4'd0, 8'd3,  1'b1, 1'b1, 8'h21}, // R6 zero count
        '{4'd10, 2'd0, 8'd63, 8'h2A, 4'd0, 8'd63, 1'b1, 1'b1, 8'h2A}, // R10 top slot
        '{4'd8,  2'd0, 8'd64, 8'h11, 4'd0, 8'd64, 1'b0, 1'b0, 8'h00}, // R8
        '{4'd4,  2'd3, 8'd0,  8'h00, 4'd0, 8'd3,  1'b0, 1'b0, 8'h00}, // R4
        '{4'd4,  2'd2, 8'd0,  8'h00, 4'd0, 8'd5,  1'b0, 1'b0, 8'h00}, // R4
        '{4'd2,  2'd0, 8'd4,  8'h11, 4'd0, 8'd4,  1'b1, 1'b1, 8'h11}, // R2
        '{4'd6,  2'd2, 8'd3,  8'h00, 4'd3, 8'd4,  1'b0, 1'b0, 8'h00}, // R6
        '{4'd3,  2'd1, 8'd4,  8'h12, 4'd0, 8'd4,  1'b1, 1'b0, 8'h12}, // R3
        '{4'd2,  2'd0, 8'd4,  8'h13, 4'd0, 8'd4,  1'b1, 1'b1, 8'h13}  // R2 overwrite
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [7:0] pg,
                         input logic [7:0] pp, input logic [3:0] cn, output int nbusy);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_page = pg; cmd_ppn = pp; cmd_count = cn;
        @(negedge clk);
        cmd_valid = 1'b0;
        nbusy = 0;
        while (busy) begin
            nbusy++;
            @(negedge clk);
        end
    endtask

    task automatic lookup(input logic [7:0] pg, output logic rd, output logic wr,
                          output logic [7:0] pp, output logic ack);
        @(negedge clk);
        lk_req = 1'b1; lk_page = pg;
        @(negedge clk);
        ack = lk_ack; rd = lk_rd_hit; wr = lk_wr_hit; pp = lk_ppn;
        lk_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic rd, wr, ack;
        logic [7:0] pp;
        int nb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 illegal", fill_illegal, 0);
        lookup(8'd0, rd, wr, pp, ack);
        chk("R1 rd page0", rd, 0);
        chk("R1 wr page0", wr, 0);
        lookup(8'd63, rd, wr, pp, ack);
        chk("R1 rd page63", rd, 0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            issue(VECS[i].op, VECS[i].page, VECS[i].ppn, VECS[i].cnt, nb);
            lookup(VECS[i].lk, rd, wr, pp, ack);
            chk({tag, " ack"}, ack, 1);
            chk({tag, " rd"}, rd, VECS[i].rd);
            chk({tag, " wr"}, wr, VECS[i].wr);
            if (VECS[i].rd) chk({tag, " ppn"}, pp, VECS[i].xppn);
        end

        // R4 flush walks only the logged pages
        issue(2'd3, 0, 0, 0, nb);
        issue(2'd0, 8'd1, 8'd1, 0, nb);
        issue(2'd0, 8'd2, 8'd2, 0, nb);
        issue(2'd0, 8'd9, 8'd9, 0, nb);
        issue(2'd3, 0, 0, 0, nb);
        chk("R4 flush busy cycles", nb, 4);
        lookup(8'd9, rd, wr, pp, ack);
        chk("R4 page9 cleared", rd, 0);
        lookup(8'd1, rd, wr, pp, ack);
        chk("R4 page1 cleared", wr, 0);

        // R6 range busy length
        issue(2'd2, 8'd0, 0, 4'd5, nb);
        chk("R6 range busy cycles", nb, 6);

        // R5 fill into full log
        for (int p = 20; p < 20 + DEPTH; p++) issue(2'd0, 8'(p), 8'(p), 0, nb);
        issue(2'd0, 8'd30, 8'd5, 0, nb);
        chk("R5 forced flush busy", nb, DEPTH + 1);
        lookup(8'd20, rd, wr, pp, ack);
        chk("R5 old page20 gone", rd, 0);
        lookup(8'd27, rd, wr, pp, ack);
        chk("R5 old page27 gone", rd, 0);
        lookup(8'd30, rd, wr, pp, ack);
        chk("R5 new page hit", rd, 1);
        chk("R5 new page ppn", pp, 5);
        issue(2'd3, 0, 0, 0, nb);
        chk("R5 log holds one", nb, 2);

        // R7 pop of newest log entry
        for (int p = 40; p < 40 + DEPTH; p++) issue(2'd0, 8'(p), 8'(p + 1), 0, nb);
        issue(2'd2, 8'(40 + DEPTH - 1), 0, 4'd1, nb);
        issue(2'd0, 8'd50, 8'd50, 0, nb);
        chk("R7 no flush after pop", nb, 0);
        lookup(8'd40, rd, wr, pp, ack);
        chk("R7 page40 kept", rd, 1);
        chk("R7 page40 ppn", pp, 41);
        issue(2'd3, 0, 0, 0, nb);
        chk("R7 log size after pop", nb, DEPTH + 1);

        // R8 illegal pulse, physical side
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_page = 8'd1; cmd_ppn = 8'd64;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R8 pulse high", fill_illegal, 1);
        @(negedge clk);
        chk("R8 pulse one cycle", fill_illegal, 0);
        lookup(8'd1, rd, wr, pp, ack);
        chk("R8 nothing stored", rd, 0);
        issue(2'd3, 0, 0, 0, nb);
        chk("R8 nothing logged", nb, 1);

        // R9 stall during flush
        issue(2'd0, 8'd50, 8'd7, 0, nb);
        issue(2'd0, 8'd51, 8'd8, 0, nb);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd3;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R9 busy seen", busy, 1);
        lk_req = 1'b1; lk_page = 8'd50;
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_page = 8'd52; cmd_ppn = 8'd9;
        @(negedge clk);
        chk("R9 no ack while busy", lk_ack, 0);
        lk_req = 1'b0; cmd_valid = 1'b0;
        while (busy) @(negedge clk);
        lookup(8'd52, rd, wr, pp, ack);
        chk("R9 dropped fill", rd, 0);
        chk("R10 ack after idle", ack, 1);
        lookup(8'd200, rd, wr, pp, ack);
        chk("R10 far page miss", rd, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule